// File: doc/BRIEF.md
# Trigger-Aligned Clock Regenerator

This block runs on a fast system clock and watches two slow inputs: a reference clock and an asynchronous trigger. While the trigger is high, it measures how many system ticks the reference spends high and how many it spends low. When the trigger falls, it starts a regenerated copy of the reference whose phase is set by that fall. The first low phase lasts the measured low width, and the copy then alternates between the measured high and low widths until the trigger rises again.

The block derives several outputs from the aligned copy: its inverse, a divide-by-two clock and that clock's inverse, and a one-shot pulse two reference periods long. A further output, the continuous clock, carries the raw reference while the trigger is high and the aligned copy while it is low, so it never stops. The trigger passes through a filter before edge detection. The filter accepts a rising edge only after the trigger has stayed high for a set number of ticks, and it accepts a falling edge at once. A typical use is to restart a pixel-clock phase at every line-sync edge.

The system clock must run at least eight times the reference frequency. Outputs carry no meaning until the trigger has been high once after reset.

Top module: `trig_clk_regen`

## Requirements
- R1: At least FILT_N+3 clk edges after the trigger input rises, and for as long as it stays high, aln_clk and half_clk are 0, aln_clk_n and half_clk_n are 1, and pulse_out is 0.
- R2: After the trigger input falls, with L and H the measured reference low and high widths in ticks, aln_clk first rises on the (L+4)th rising clk edge. The first edge that samples the trigger low counts as the first. From there aln_clk is high for H ticks and low for L ticks, repeating.
- R3: half_clk is 0 before the first aln_clk rise after a trigger fall, toggles with every aln_clk rise, and rises together with the first one. aln_clk_n and half_clk_n are always the complements of aln_clk and half_clk.
- R4: pulse_out rises on the 4th clk edge after the trigger fall, counted as in R2, and stays high for exactly 2*(H+L) ticks. It then stays low until the next accepted trigger fall.
- R5: While the filtered trigger is high, cont_clk equals ref_in as it was two clk edges earlier. While the filtered trigger is low, cont_clk equals aln_clk.
- R6: A high level on the trigger input lasting fewer than FILT_N clk edges is ignored, and the aligned outputs continue undisturbed. A high level lasting FILT_N edges is accepted, so the following fall starts a new pulse.
- R7: The high and low widths are captured only while the filtered trigger is high. A change in the reference while the trigger is low does not alter the aligned outputs. The next high period measures the new widths.
- R8: Every accepted trigger fall produces the same output sequence for the same reference, because the phase counter, the divide-by-two flop and the pulse counter restart on each rise.
- R9: While rst_n is low, aln_clk and half_clk are 0, aln_clk_n and half_clk_n are 1, and pulse_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock, asynchronous |
| trig_in | input | 1 | Trigger, asynchronous; falling edge sets phase |
| aln_clk | output | 1 | Trigger-aligned clock |
| aln_clk_n | output | 1 | Inverse of aln_clk |
| half_clk | output | 1 | aln_clk divided by two |
| half_clk_n | output | 1 | Inverse of half_clk |
| pulse_out | output | 1 | One-shot pulse, two reference periods |
| cont_clk | output | 1 | Raw reference while trigger high, aln_clk while low |

## Verification
A wrong captured width shows up at the first aln_clk rise, which lands off its L+4 edge, or in the first high phase, which comes out the wrong length. Either appears within one reference period of the fall. A divide-by-two flop or pulse counter left uncleared shows up on the second trigger fall, as a half_clk that starts high or a pulse with the wrong length. A trigger filter that passes short glitches stops the aligned clock within a few ticks of the glitch, so the cycle-by-cycle comparison flags it immediately. Widths captured while the trigger is low show up in the first reference period after the change.

// File: rtl/regen_pkg.sv
package regen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/regen_sync.sv
module regen_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/regen_trig_filter.sv
module regen_trig_filter #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_s,
  output logic trig_f
);
  localparam int CW = $clog2(FILT_N + 1);

  logic          f_q, f_n;
  logic [CW-1:0] c_q, c_n;

  always_comb begin
    f_n = f_q;
    c_n = c_q;
    if (!trig_s) begin
      f_n = 1'b0;
      c_n = '0;
    end else if (!f_q) begin
      if (c_q == CW'(FILT_N - 1)) f_n = 1'b1;
      else                        c_n = c_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      c_q <= '0;
    end else begin
      f_q <= f_n;
      c_q <= c_n;
    end
  end

  assign trig_f = f_q;

  // R6: a low synchronized trigger drops the filtered trigger at once
  assert_fall_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_s |=> !trig_f);
  // R6: acceptance of a rise needs the synchronized input to have been high
  assert_rise_needs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_f) |-> $past(trig_s));
endmodule

// File: rtl/regen_meter.sv
module regen_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_s,
  input  logic             trig_f,
  output logic [CNT_W-1:0] lo_w,
  output logic [CNT_W-1:0] hi_w
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic             ref_d_q;
  logic [CNT_W-1:0] run_q, run_n;
  logic [CNT_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic             edge_seen;

  assign edge_seen = ref_s ^ ref_d_q;

  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (edge_seen)              run_n = {{(CNT_W-1){1'b0}}, 1'b1};
    else if (run_q == RUN_MAX)  run_n = run_q;
    else                        run_n = run_q + 1'b1;
    if (edge_seen && trig_f) begin
      if (ref_s) lo_n = run_q;
      else       hi_n = run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d_q <= 1'b0;
      run_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
      lo_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
      hi_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
    end else begin
      ref_d_q <= ref_s;
      run_q   <= run_n;
      lo_q    <= lo_n;
      hi_q    <= hi_n;
    end
  end

  assign lo_w = lo_q;
  assign hi_w = hi_q;

  // R7: widths hold while the filtered trigger is low
  assert_frozen_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_f |=> ($stable(lo_q) && $stable(hi_q)));
  // R7: a captured width is never zero
  assert_width_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q != '0) && (hi_q != '0));
endmodule

// File: rtl/regen_phase_gen.sv
module regen_phase_gen
  import regen_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_f,
  input  logic [CNT_W-1:0] lo_w,
  input  logic [CNT_W-1:0] hi_w,
  output logic             aln_o,
  output logic             half_o,
  output logic             pulse_o
);
  localparam int PL_W = CNT_W + 2;

  phase_e           state_q, state_n;
  logic [CNT_W-1:0] ph_q, ph_n;
  logic             half_q, half_n;
  logic             pulse_q, pulse_n;
  logic [PL_W-1:0]  pc_q, pc_n;
  logic             trig_d_q;
  logic             fall;
  logic [PL_W-1:0]  pulse_len;

  assign fall      = trig_d_q & ~trig_f;
  assign pulse_len = (PL_W'(lo_w) + PL_W'(hi_w)) << 1;

  always_comb begin
    state_n = state_q;
    ph_n    = ph_q;
    half_n  = half_q;
    pulse_n = pulse_q;
    pc_n    = pc_q;
    if (trig_f) begin
      state_n = PH_IDLE;
      ph_n    = '0;
      half_n  = 1'b0;
      pulse_n = 1'b0;
      pc_n    = '0;
    end else if (fall) begin
      state_n = PH_LOW;
      ph_n    = {{(CNT_W-1){1'b0}}, 1'b1};
      pulse_n = 1'b1;
      pc_n    = {{(PL_W-1){1'b0}}, 1'b1};
    end else begin
      case (state_q)
        PH_LOW: begin
          if (ph_q == lo_w) begin
            state_n = PH_HIGH;
            ph_n    = {{(CNT_W-1){1'b0}}, 1'b1};
            half_n  = ~half_q;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (ph_q == hi_w) begin
            state_n = PH_LOW;
            ph_n    = {{(CNT_W-1){1'b0}}, 1'b1};
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
        default: state_n = PH_IDLE;
      endcase
      if (pulse_q) begin
        if (pc_q == pulse_len) pulse_n = 1'b0;
        else                   pc_n    = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      ph_q     <= '0;
      half_q   <= 1'b0;
      pulse_q  <= 1'b0;
      pc_q     <= '0;
      trig_d_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      ph_q     <= ph_n;
      half_q   <= half_n;
      pulse_q  <= pulse_n;
      pc_q     <= pc_n;
      trig_d_q <= trig_f;
    end
  end

  assign aln_o   = (state_q == PH_HIGH);
  assign half_o  = half_q;
  assign pulse_o = pulse_q;

  // R1: one cycle of high filtered trigger leaves every gated output idle
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(trig_f) |-> (state_q == PH_IDLE && !half_q && !pulse_q));
  // R2: an accepted fall starts in the low phase
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (state_q == PH_LOW && !aln_o));
  // R3: the divider changes state on every aligned clock rise
  assert_div_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aln_o) |-> (half_q != $past(half_q)));
  // R4: the pulse counter never runs past its length
  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (pc_q != '0 && pc_q <= pulse_len));
endmodule

// File: rtl/trig_clk_regen.sv
module trig_clk_regen #(
  parameter int CNT_W  = 8,
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic trig_in,
  output logic aln_clk,
  output logic aln_clk_n,
  output logic half_clk,
  output logic half_clk_n,
  output logic pulse_out,
  output logic cont_clk
);
  localparam int SYNC_STAGES = 2;

  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [1:0]       sync_q;
  logic             ref_s, trig_s, trig_f;
  logic [CNT_W-1:0] lo_w, hi_w;
  logic             aln, half, pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  regen_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_in  ({trig_in, ref_in}),
    .q_out (sync_q)
  );
  assign ref_s  = sync_q[0];
  assign trig_s = sync_q[1];

  regen_trig_filter #(.FILT_N(FILT_N)) u_filt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .trig_s (trig_s),
    .trig_f (trig_f)
  );

  regen_meter #(.CNT_W(CNT_W)) u_meter (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ref_s  (ref_s),
    .trig_f (trig_f),
    .lo_w   (lo_w),
    .hi_w   (hi_w)
  );

  regen_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .trig_f  (trig_f),
    .lo_w    (lo_w),
    .hi_w    (hi_w),
    .aln_o   (aln),
    .half_o  (half),
    .pulse_o (pulse)
  );

  assign aln_clk    = aln;
  assign aln_clk_n  = ~aln;
  assign half_clk   = half;
  assign half_clk_n = ~half;
  assign pulse_out  = pulse;
  assign cont_clk   = trig_f ? ref_s : aln;
endmodule

// File: tb/trig_clk_regen_test.sv
`timescale 1ns/1ps
module trig_clk_regen_test;
  localparam int FILT_N = 4;

  logic clk = 1'b0;
  logic rst_n, ref_in, trig_in;
  logic aln_clk, aln_clk_n, half_clk, half_clk_n, pulse_out, cont_clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int rhi = 7;
  int rper = 16;
  int rc = 0;
  logic refd0 = 1'b0, refd1 = 1'b0, refd2 = 1'b0;

  always #2 clk = ~clk;

  trig_clk_regen #(.CNT_W(8), .FILT_N(FILT_N)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .trig_in(trig_in),
    .aln_clk(aln_clk), .aln_clk_n(aln_clk_n), .half_clk(half_clk),
    .half_clk_n(half_clk_n), .pulse_out(pulse_out), .cont_clk(cont_clk)
  );

  initial begin
    ref_in = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      rc = rc + 1;
      if (rc >= rper) rc = 0;
      ref_in = (rc < rhi);
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    refd2 = refd1;
    refd1 = refd0;
    refd0 = ref_in;
  endtask

  task automatic check_reset();
    check("R9", "aln_clk in reset", aln_clk, 0);
    check("R9", "aln_clk_n in reset", aln_clk_n, 1);
    check("R9", "half_clk in reset", half_clk, 0);
    check("R9", "half_clk_n in reset", half_clk_n, 1);
    check("R9", "pulse_out in reset", pulse_out, 0);
  endtask

  task automatic idle_check(input string tag, input int n);
    int bad_idle = 0;
    int bad_cont = 0;
    int fa = 0, fe = 0;
    for (int k = 0; k < n; k++) begin
      tick();
      if (aln_clk !== 1'b0 || aln_clk_n !== 1'b1 || half_clk !== 1'b0 ||
          half_clk_n !== 1'b1 || pulse_out !== 1'b0) bad_idle++;
      if (cont_clk !== refd2) begin
        if (bad_cont == 0) begin fa = cont_clk; fe = refd2; end
        bad_cont++;
      end
    end
    check(tag, "idle output samples off", bad_idle, 0);
    check("R5", "cont_clk vs delayed ref", fa, fe);
  endtask

  task automatic raise_trig(input int n);
    @(posedge clk); #1; trig_in = 1'b1;
    for (int k = 0; k < n; k++) tick();
  endtask

  // Cycle-by-cycle comparison after a trigger fall
  task automatic stream(input int hi, input int lo, input int kmax, input int glitch_at,
                        input int chg_at, input int chg_hi, input int chg_per,
                        input string tag);
    int p = hi + lo;
    int mm [6];
    int fa [6];
    int fe [6];
    int act [6];
    int exp_v [6];
    string nm [6];
    string tg [6];
    nm[0] = "aln_clk"; nm[1] = "aln_clk_n"; nm[2] = "half_clk";
    nm[3] = "half_clk_n"; nm[4] = "pulse_out"; nm[5] = "cont_clk";
    tg[0] = "R2"; tg[1] = "R3"; tg[2] = "R3"; tg[3] = "R3"; tg[4] = "R4"; tg[5] = "R5";
    for (int i = 0; i < 6; i++) begin mm[i] = 0; fa[i] = 0; fe[i] = 0; end
    @(posedge clk); #1; trig_in = 1'b0;
    tick();
    for (int k = 1; k <= kmax; k++) begin
      int rel;
      tick();
      rel = k - (lo + 4);
      exp_v[0] = (rel >= 0 && (rel % p) < hi) ? 1 : 0;
      exp_v[1] = 1 - exp_v[0];
      exp_v[2] = (rel >= 0 && ((rel / p) % 2) == 0) ? 1 : 0;
      exp_v[3] = 1 - exp_v[2];
      exp_v[4] = (k >= 4 && k < 4 + 2 * p) ? 1 : 0;
      exp_v[5] = (k <= 2) ? int'(refd2) : exp_v[0];
      act[0] = aln_clk; act[1] = aln_clk_n; act[2] = half_clk;
      act[3] = half_clk_n; act[4] = pulse_out; act[5] = cont_clk;
      for (int i = 0; i < 6; i++) begin
        if (act[i] != exp_v[i]) begin
          if (mm[i] == 0) begin fa[i] = act[i]; fe[i] = exp_v[i]; end
          mm[i]++;
        end
      end
      if (glitch_at > 0 && k == glitch_at) trig_in = 1'b1;
      if (glitch_at > 0 && k == glitch_at + FILT_N - 1) trig_in = 1'b0;
      if (chg_at > 0 && k == chg_at) begin rhi = chg_hi; rper = chg_per; end
    end
    for (int i = 0; i < 6; i++)
      check((tag == "") ? tg[i] : tag, nm[i], fa[i], fe[i]);
  endtask

  // R6: short high rejected, full-length high accepted
  task automatic filter_accept();
    int seen = 0;
    @(posedge clk); #1; trig_in = 1'b1;
    repeat (FILT_N - 1) @(posedge clk);
    #1; trig_in = 1'b0;
    for (int k = 0; k < 16; k++) begin tick(); if (pulse_out) seen++; end
    check("R6", "pulse after short high", seen, 0);
    @(posedge clk); #1; trig_in = 1'b1;
    repeat (FILT_N) @(posedge clk);
    #1; trig_in = 1'b0;
    seen = 0;
    for (int k = 0; k < 16; k++) begin tick(); if (pulse_out) seen++; end
    check("R6", "pulse after full high", (seen > 0) ? 1 : 0, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    trig_in = 1'b1;
    repeat (5) tick();
    check_reset();
    @(posedge clk); #1; rst_n = 1'b1;
    for (int k = 0; k < 60; k++) tick();
    idle_check("R1", 30);
    stream(7, 9, 80, 0, 0, 0, 0, "");
    raise_trig(30);
    idle_check("R1", 20);
    stream(7, 9, 80, 50, 0, 0, 0, "R8 R6");
    raise_trig(30);
    stream(7, 9, 80, 0, 20, 5, 10, "R7");
    raise_trig(50);
    stream(5, 5, 60, 0, 0, 0, 0, "R7");
    filter_accept();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule